// File: doc/BRIEF.md
# Split-Half Skewed Directory Lookup

This unit performs the tag search of a coherence directory that keeps two kinds of entries in one shared array: entries that track a single cache block, and entries that track a whole aligned region of blocks owned by one core. A request address yields a block key and a region key. One registered access probes all ways at once. For the addressed region, half of the ways are searched for its region entry and the other half for block entries. The response therefore reports a block hit, a region hit, both, or neither, together with the hitting way and the stored payload of each.

Each way computes its own set index from an XOR-matrix hash of the key, which is the kind bit followed by the tag. The matrix rows are fixed pseudo-random constants that differ per way. Entries are installed through a write port that names the way explicitly, so an external replacement engine decides placement. The array size is a parameter: `SET_BITS=12` gives 4096 sets per way, and the default is kept smaller.

Top module: `dir_lookup`

## Requirements
- R1: The block tag is `addr[ADDR_W-1:BLK_OFF]`. The region tag is `addr[ADDR_W-1:REG_OFF]`, zero-extended in its upper bits to the block tag width. The key is `{kind, tag}`, where kind 1 means region and 0 means block. Address bits below `BLK_OFF` never affect a lookup.
- R2: Let `sel` be the XOR of all region-tag bits. When `sel`=1, region entries of that region are searched in ways `WAYS/2..WAYS-1` and its block entries in ways `0..WAYS/2-1`. When `sel`=0 the two halves are swapped.
- R3: One lookup reports the block result and the region result independently, so both, either or neither may hit.
- R4: A way hits only if its indexed entry is valid and its stored key (kind and tag) equals the probed key. An entry written with the valid flag cleared is never reported.
- R5: On a hit, the reported way is the way the entry was installed in, and the reported data is the data last written to it.
- R6: `rsp_valid` is high exactly in the cycle after `lk_en`. Hit, way and data outputs keep their values while no lookup is issued.
- R7: A lookup in the cycle after a write sees the written contents. A write and a lookup in the same cycle to the same entry also return the written contents.
- R8: A write with the valid flag set must name a way in the half permitted by R2 for its kind. A write with the valid flag cleared may name any way.
- R9: While reset is asserted, `rsp_valid`, `blk_hit` and `reg_hit` are 0. After reset every entry is invalid.
- R10: On a miss of either kind, that kind's way output reads 0 and its data output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_en | input | 1 | Issue a lookup this cycle |
| lk_addr | input | ADDR_W | Lookup byte address |
| wr_en | input | 1 | Write one entry this cycle |
| wr_way | input | $clog2(WAYS) | Way to write |
| wr_addr | input | ADDR_W | Address that forms the written key |
| wr_region | input | 1 | Kind of written entry, 1 = region |
| wr_valid | input | 1 | Valid flag to store (0 invalidates) |
| wr_data | input | DATA_W | Payload to store |
| rsp_valid | output | 1 | Lookup result present |
| blk_hit | output | 1 | Block entry found |
| blk_way | output | $clog2(WAYS) | Way of the block hit |
| blk_data | output | DATA_W | Payload of the block hit |
| reg_hit | output | 1 | Region entry found |
| reg_way | output | $clog2(WAYS) | Way of the region hit |
| reg_data | output | DATA_W | Payload of the region hit |

## Verification
The assertions check on every cycle that valid installs land in the permitted half, that a reported region hit lies in the half chosen by the parity of the previous lookup's region tag, that at most one way of each half hits, and that the response timing and output holding are correct. They also check that a same-cycle write to the probed entry is forwarded into the response. Only the bench's scenarios can show that the right payload comes back from the right way, that invalidated entries and other regions miss, and that offset bits are ignored. The bench sweeps every region of a small configuration, installing a region entry and a block entry in varying ways and probing several addresses around them.

// File: rtl/dgd_pkg.sv
package dgd_pkg;

  // Row generator for the per-way XOR-matrix index hash.
  // A xorshift mix of a seed that combines the way and row numbers.
  function automatic logic [63:0] h3_row(int unsigned way_id, int unsigned row);
    logic [63:0] s;
    s = 64'h9E37_79B9_7F4A_7C15 ^ {way_id, row};
    for (int k = 0; k < 6; k++) begin
      s = s ^ (s << 13);
      s = s ^ (s >> 7);
      s = s ^ (s << 17);
    end
    return s;
  endfunction

endpackage

// File: rtl/dl_h3.sv
module dl_h3 #(
  parameter int WAY_ID = 0,
  parameter int KEY_W  = 27,
  parameter int IDX_W  = 9
) (
  input  logic [KEY_W-1:0] key,
  output logic [IDX_W-1:0] idx
);
  import dgd_pkg::*;

  // Each index bit is the parity of the key masked by one matrix row.
  for (genvar i = 0; i < IDX_W; i++) begin : g_row
    localparam logic [63:0] ROW = h3_row(WAY_ID, i);
    assign idx[i] = ^(key & ROW[KEY_W-1:0]);
  end

endmodule

// File: rtl/dl_way.sv
module dl_way #(
  parameter int WAY_ID   = 0,
  parameter int KEY_W    = 27,
  parameter int DATA_W   = 16,
  parameter int SET_BITS = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_en,
  input  logic [KEY_W-1:0]  lk_key,
  input  logic              wr_en,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hit_q,
  output logic [DATA_W-1:0] data_q
);
  localparam int SETS = 1 << SET_BITS;

  logic [SET_BITS-1:0] rd_idx;
  logic [SET_BITS-1:0] wr_idx;

  dl_h3 #(.WAY_ID(WAY_ID), .KEY_W(KEY_W), .IDX_W(SET_BITS)) u_rd_hash (
    .key(lk_key),
    .idx(rd_idx)
  );

  dl_h3 #(.WAY_ID(WAY_ID), .KEY_W(KEY_W), .IDX_W(SET_BITS)) u_wr_hash (
    .key(wr_key),
    .idx(wr_idx)
  );

  logic [KEY_W-1:0]  key_mem [SETS];
  logic [DATA_W-1:0] dat_mem [SETS];
  logic [SETS-1:0]   vld_q;
  logic [SETS-1:0]   vld_d;

  // Valid bits: next state
  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_idx] = wr_valid;
  end

  // Valid bits: register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // Key and payload storage, no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      key_mem[wr_idx] <= wr_key;
      dat_mem[wr_idx] <= wr_data;
    end
  end

  // Read with same-cycle forwarding of a write to the probed set
  logic              fwd;
  logic              ent_v;
  logic [KEY_W-1:0]  ent_k;
  logic [DATA_W-1:0] ent_d;
  logic              hit_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    fwd    = wr_en && (wr_idx == rd_idx);
    ent_v  = fwd ? wr_valid : vld_q[rd_idx];
    ent_k  = fwd ? wr_key   : key_mem[rd_idx];
    ent_d  = fwd ? wr_data  : dat_mem[rd_idx];
    hit_d  = ent_v && (ent_k == lk_key);
    data_d = hit_d ? ent_d : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      data_q <= '0;
    end else if (lk_en) begin
      hit_q  <= hit_d;
      data_q <= data_d;
    end
  end

  // R7: a valid write of the probed key in the lookup cycle is seen
  a_r7_same_cycle_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && wr_en && wr_valid && (wr_idx == rd_idx) && (wr_key == lk_key)) |=> hit_q);

endmodule

// File: rtl/dir_lookup.sv
module dir_lookup #(
  parameter int ADDR_W   = 32,
  parameter int BLK_OFF  = 6,
  parameter int REG_OFF  = 10,
  parameter int WAYS     = 8,
  parameter int SET_BITS = 9,
  parameter int DATA_W   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lk_en,
  input  logic [ADDR_W-1:0]       lk_addr,
  input  logic                    wr_en,
  input  logic [$clog2(WAYS)-1:0] wr_way,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic                    wr_region,
  input  logic                    wr_valid,
  input  logic [DATA_W-1:0]       wr_data,
  output logic                    rsp_valid,
  output logic                    blk_hit,
  output logic [$clog2(WAYS)-1:0] blk_way,
  output logic [DATA_W-1:0]       blk_data,
  output logic                    reg_hit,
  output logic [$clog2(WAYS)-1:0] reg_way,
  output logic [DATA_W-1:0]       reg_data
);
  localparam int HALF   = WAYS / 2;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int BTAG_W = ADDR_W - BLK_OFF;
  localparam int RTAG_W = ADDR_W - REG_OFF;
  localparam int PAD_W  = BTAG_W - RTAG_W;
  localparam int KEY_W  = BTAG_W + 1;

  // Key formation
  function automatic logic [KEY_W-1:0] mk_key(logic [ADDR_W-1:0] a, logic is_reg);
    logic [KEY_W-1:0] k;
    if (is_reg) k = {1'b1, {PAD_W{1'b0}}, a[ADDR_W-1:REG_OFF]};
    else        k = {1'b0, a[ADDR_W-1:BLK_OFF]};
    return k;
  endfunction

  logic [KEY_W-1:0] lk_bkey, lk_rkey, wr_key;
  logic             lk_sel, wr_sel;
  logic             unused_lo;

  assign lk_bkey   = mk_key(lk_addr, 1'b0);
  assign lk_rkey   = mk_key(lk_addr, 1'b1);
  assign wr_key    = mk_key(wr_addr, wr_region);
  assign lk_sel    = ^lk_addr[ADDR_W-1:REG_OFF];
  assign wr_sel    = ^wr_addr[ADDR_W-1:REG_OFF];
  assign unused_lo = ^{lk_addr[BLK_OFF-1:0], wr_addr[BLK_OFF-1:0]};

  // Way array
  logic [WAYS-1:0]   way_hit;
  logic [DATA_W-1:0] way_data [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    localparam logic UPPER = (w >= HALF);
    logic             probe_reg;
    logic [KEY_W-1:0] probe_key;
    logic             wsel;

    assign probe_reg = (UPPER == lk_sel);
    assign probe_key = probe_reg ? lk_rkey : lk_bkey;
    assign wsel      = wr_en && (wr_way == WAY_W'(w));

    dl_way #(
      .WAY_ID  (w),
      .KEY_W   (KEY_W),
      .DATA_W  (DATA_W),
      .SET_BITS(SET_BITS)
    ) u_way (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_en   (lk_en),
      .lk_key  (probe_key),
      .wr_en   (wsel),
      .wr_key  (wr_key),
      .wr_valid(wr_valid),
      .wr_data (wr_data),
      .hit_q   (way_hit[w]),
      .data_q  (way_data[w])
    );
  end

  // Response state: next state and register
  logic rsp_valid_d, rsp_valid_q;
  logic sel_d, sel_q;

  always_comb begin
    rsp_valid_d = lk_en;
    sel_d       = lk_en ? lk_sel : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      sel_q       <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      sel_q       <= sel_d;
    end
  end

  // Split hits by half and encode
  logic [WAYS-1:0] reg_mask, blk_vec, reg_vec;

  function automatic logic [WAY_W-1:0] first_one(logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (v[i]) r = WAY_W'(i);
    end
    return r;
  endfunction

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      reg_mask[w] = ((w >= HALF) == sel_q);
    end
    blk_vec  = way_hit & ~reg_mask;
    reg_vec  = way_hit & reg_mask;
    blk_data = '0;
    reg_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (blk_vec[w]) blk_data = blk_data | way_data[w];
      if (reg_vec[w]) reg_data = reg_data | way_data[w];
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign blk_hit   = |blk_vec;
  assign reg_hit   = |reg_vec;
  assign blk_way   = first_one(blk_vec);
  assign reg_way   = first_one(reg_vec);

  // R8: valid installs only in the permitted half for their kind
  a_r8_install_half: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_valid) |->
      ((wr_way >= WAY_W'(HALF)) == (wr_region ? wr_sel : !wr_sel)));

  // R6: response strobe follows the request by exactly one cycle
  a_r6_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    lk_en |=> rsp_valid);
  a_r6_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |=> !rsp_valid);
  a_r6_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |=> ($stable(blk_hit) && $stable(reg_hit) && $stable(blk_data) && $stable(reg_data)));

  // R2: a region hit comes from the half chosen by the region-tag parity
  a_r2_region_half: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && reg_hit) |-> ((reg_way >= WAY_W'(HALF)) == $past(lk_sel)));

  // R3: at most one way of each half holds a matching entry
  a_r3_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($onehot0(blk_vec) && $onehot0(reg_vec)));

endmodule

// File: tb/test_dir_lookup.sv
`timescale 1ns/1ps
module test_dir_lookup;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              lk_en;
  logic [ADDR_W-1:0] lk_addr;
  logic              wr_en;
  logic [2:0]        wr_way;
  logic [ADDR_W-1:0] wr_addr;
  logic              wr_region, wr_valid;
  logic [DATA_W-1:0] wr_data;
  logic              rsp_valid, blk_hit, reg_hit;
  logic [2:0]        blk_way, reg_way;
  logic [DATA_W-1:0] blk_data, reg_data;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  dir_lookup #(
    .ADDR_W(ADDR_W), .BLK_OFF(6), .REG_OFF(10),
    .WAYS(8), .SET_BITS(4), .DATA_W(DATA_W)
  ) i_dir_lookup (
    .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_addr(lk_addr),
    .wr_en(wr_en), .wr_way(wr_way), .wr_addr(wr_addr), .wr_region(wr_region),
    .wr_valid(wr_valid), .wr_data(wr_data), .rsp_valid(rsp_valid),
    .blk_hit(blk_hit), .blk_way(blk_way), .blk_data(blk_data),
    .reg_hit(reg_hit), .reg_way(reg_way), .reg_data(reg_data)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [2:0] w, logic isr, logic v, logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_way = w; wr_region = isr; wr_valid = v; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(logic [ADDR_W-1:0] a, logic ebh, logic [2:0] ebw, logic [DATA_W-1:0] ebd,
                      logic erh, logic [2:0] erw, logic [DATA_W-1:0] erd, string req);
    @(negedge clk);
    lk_en = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_en = 1'b0;
    chk(req, "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(req, "blk_hit",   32'(blk_hit),   32'(ebh));
    chk(req, "blk_way",   32'(blk_way),   32'(ebw));
    chk(req, "blk_data",  32'(blk_data),  32'(ebd));
    chk(req, "reg_hit",   32'(reg_hit),   32'(erh));
    chk(req, "reg_way",   32'(reg_way),   32'(erw));
    chk(req, "reg_data",  32'(reg_data),  32'(erd));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_en = 1'b0; lk_addr = '0; wr_en = 1'b0; wr_way = '0;
    wr_addr = '0; wr_region = 1'b0; wr_valid = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R9: quiet outputs during reset
    chk("R9", "rsp_valid in reset", 32'(rsp_valid), 0);
    chk("R9", "blk_hit in reset",   32'(blk_hit),   0);
    chk("R9", "reg_hit in reset",   32'(reg_hit),   0);
    rst_n = 1'b1;
    // R9 / R10: empty array misses with zero way and data
    look(16'h0000, 0, 0, 0, 0, 0, 0, "R9");
    look(16'hFFC0, 0, 0, 0, 0, 0, 0, "R10");

    // Sweep every region of the small configuration (R1..R5, R10)
    for (int r = 0; r < 64; r++) begin
      logic [5:0]  rt;
      logic        sel;
      logic [2:0]  rw, bw;
      logic [15:0] rbase, blka, blkb, other;
      rt    = 6'(r);
      sel   = ^rt;                                   // R2 parity rule
      rw    = sel ? 3'(4 + r % 4) : 3'(r % 4);
      bw    = sel ? 3'((r + 1) % 4) : 3'(4 + (r + 1) % 4);
      rbase = {rt, 10'h000};
      blka  = {rt, 4'(r % 16), 6'h00};
      blkb  = {rt, 4'((r + 5) % 16), 6'h15};
      other = {6'(r + 1), 10'h3C0};
      wr(rbase, rw, 1'b1, 1'b1, 16'hA000 | 16'(r));
      look(blka, 0, 0, 0, 1, rw, 16'hA000 | 16'(r), "R3");
      wr(blka, bw, 1'b0, 1'b1, 16'hB000 | 16'(r));
      look(blka, 1, bw, 16'hB000 | 16'(r), 1, rw, 16'hA000 | 16'(r), "R5");
      look(blka | 16'h003F, 1, bw, 16'hB000 | 16'(r), 1, rw, 16'hA000 | 16'(r), "R1");
      look(blkb, 0, 0, 0, 1, rw, 16'hA000 | 16'(r), "R10");
      look(other, 0, 0, 0, 0, 0, 0, "R3");
      wr(rbase, rw, 1'b1, 1'b0, 16'h0000);
      wr(blka, bw, 1'b0, 1'b0, 16'h0000);
      look(blka, 0, 0, 0, 0, 0, 0, "R4");
    end

    // R7: same-cycle write and lookup; region 4 has parity 1, block ways 0..3
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'h1240; wr_way = 3'd2; wr_region = 1'b0;
    wr_valid = 1'b1; wr_data = 16'h5A5A;
    lk_en = 1'b1; lk_addr = 16'h1240;
    @(negedge clk);
    wr_en = 1'b0; lk_en = 1'b0;
    chk("R7", "fwd blk_hit",  32'(blk_hit),  1);
    chk("R7", "fwd blk_way",  32'(blk_way),  2);
    chk("R7", "fwd blk_data", 32'(blk_data), 32'h5A5A);
    // R7: next-cycle read after overwrite (R5 data replaced)
    @(negedge clk);
    wr_en = 1'b1; wr_data = 16'h6B6B; wr_valid = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    lk_en = 1'b1;
    @(negedge clk);
    lk_en = 1'b0;
    chk("R7", "next blk_data", 32'(blk_data), 32'h6B6B);
    // R6: outputs hold while idle, strobe low
    @(negedge clk);
    chk("R6", "rsp_valid idle", 32'(rsp_valid), 0);
    chk("R6", "blk_hit held",   32'(blk_hit),   1);
    chk("R6", "blk_data held",  32'(blk_data),  32'h6B6B);
    @(negedge clk);
    chk("R6", "blk_way held",   32'(blk_way),   2);
    // R7 / R4: same-cycle invalidate is seen as a miss
    @(negedge clk);
    wr_en = 1'b1; wr_valid = 1'b0; lk_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; lk_en = 1'b0;
    chk("R7", "fwd invalidate", 32'(blk_hit), 0);
    look(16'h1240, 0, 0, 0, 0, 0, 0, "R4");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule